// File: doc/BRIEF.md
# Reset Source and Status Flag Controller

This block sits beside the core of a small microcontroller. It decides what kind of reset each request causes and keeps two software-visible status bits. The time-out flag (`toFlag`) records that the watchdog expired. The power-down flag (`pdFlag`) records that the part was sleeping.

Four sources can start a reset:
- a power-on pulse, which acts asynchronously;
- an external reset pin;
- a low-voltage request;
- a watchdog expiry.

The pin and low-voltage requests pass through a clock synchroniser. A watchdog expiry while awake produces a full reset. A watchdog expiry while asleep produces only a partial wake reset, which clears the program counter and stack pointer and leaves every other piece of state alone.

Every reset is stretched by a start-up counter. The counter is long by default. It is short only when the short setting is selected and the clock is not taken from a crystal. Both reset outputs release on a single clock edge when the count ends. Software clears both flags with a strobe. Entering sleep sets the power-down flag.

Top module: `rst_source_ctrl`

## Requirements
- R1: While `powerOn` is high, `toFlag`=0, `pdFlag`=0, `fullRst`=1 and `wakeRst`=0. After `powerOn` falls, `fullRst` stays high for the start-up length and then falls.
- R2: A pin or low-voltage request reaches the logic after SYNC_STAGES (2) clock edges. It raises `fullRst` on the following edge and leaves `toFlag` and `pdFlag` unchanged.
- R3: A `wdtExpire` pulse while `sleepMode`=0 raises `fullRst` on the next edge, sets `toFlag`=1 and leaves `pdFlag` unchanged.
- R4: A `wdtExpire` pulse while `sleepMode`=1 sets `toFlag`=1 and `pdFlag`=1 and raises `wakeRst` only. `fullRst` stays 0.
- R5: When a synchronised pin or low-voltage request and `wdtExpire` arrive in the same cycle, the pin behaviour applies: `fullRst`=1 and `toFlag` unchanged.
- R6: The start-up length is SHORT_CYCLES (2) when `fastStart`=1 and `xtalClk`=0, and LONG_CYCLES (1024) otherwise. A reset output stays high for exactly that many cycles after the edge that raised it.
- R7: A new request that arrives while the start-up count is running restarts the count from zero.
- R8: `flagClr`=1 clears both flags when no reset output is high. It has no effect while `fullRst` or `wakeRst` is high.
- R9: `sleepMode`=1 with no reset output high sets `pdFlag`=1. This setting wins over a `flagClr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| powerOn | input | 1 | Power-on reset pulse, active high, asynchronous |
| extPin | input | 1 | External reset request, active high, asynchronous |
| lvrReq | input | 1 | Low-voltage reset request, active high, asynchronous |
| wdtExpire | input | 1 | Watchdog time-out pulse, synchronous to `clk` |
| sleepMode | input | 1 | High while the core is powered down |
| flagClr | input | 1 | Software strobe that clears both flags |
| fastStart | input | 1 | Selects the short start-up length |
| xtalClk | input | 1 | High when the clock comes from a crystal |
| toFlag | output | 1 | Time-out status flag |
| pdFlag | output | 1 | Power-down status flag |
| fullRst | output | 1 | Full internal reset (watchdog, interrupts, timer, prescaler, I/O direction) |
| wakeRst | output | 1 | Partial reset of program counter and stack pointer only |

## Verification
The assertions check these relations on every cycle:
- how each request cause updates the two flags one edge later;
- that the wake reset is never high together with the full reset;
- that the clear strobe is ignored while a reset is active;
- that any request asserts a reset output.

Only the bench scenarios can show the things that depend on long spans of time:
- the exact start-up length in both the short and the long setting;
- the two-edge synchroniser delay;
- the restart of the count by a second request;
- that both outputs release on the expected edge.

// File: rtl/rst_source_pkg.sv
`timescale 1ns/1ps
package rst_source_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_FULL = 2'd1,
    MODE_WAKE = 2'd2
  } rstMode_e;

  typedef struct packed {
    logic restart;   // clear start-up counter
    logic run;       // counter advances
    logic setTo;     // raise time-out flag
    logic setPd;     // raise power-down flag
    logic clrFlags;  // software clear of both flags
  } flagCmd_t;

endpackage

// File: rtl/rst_source_fsm.sv
`timescale 1ns/1ps
module rst_source_fsm
  import rst_source_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     powerOn,
  input  logic     extPin,
  input  logic     lvrReq,
  input  logic     wdtExpire,
  input  logic     sleepMode,
  input  logic     flagClr,
  input  logic     cntDone,
  output flagCmd_t cmd,
  output rstMode_e mode,
  output logic     pinEvt
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] pinSync;
  logic [MSB:0] lvrSync;

  // Two-or-more flop synchronisers, cleared by power-on
  always_ff @(posedge clk or posedge powerOn) begin
    if (powerOn) begin
      pinSync <= '0;
      lvrSync <= '0;
    end else begin
      pinSync <= {pinSync[MSB-1:0], extPin};
      lvrSync <= {lvrSync[MSB-1:0], lvrReq};
    end
  end

  assign pinEvt = pinSync[MSB] | lvrSync[MSB];

  logic wdtFull;
  logic wdtWake;
  logic isIdle;

  assign wdtFull = wdtExpire & ~sleepMode & ~pinEvt;
  assign wdtWake = wdtExpire &  sleepMode & ~pinEvt;
  assign isIdle  = (mode == MODE_IDLE);

  always_ff @(posedge clk or posedge powerOn) begin
    if (powerOn) begin
      mode <= MODE_FULL;
    end else if (pinEvt || wdtFull) begin
      mode <= MODE_FULL;
    end else if (wdtWake) begin
      mode <= (mode == MODE_FULL) ? MODE_FULL : MODE_WAKE;
    end else if (cntDone) begin
      mode <= MODE_IDLE;
    end
  end

  always_comb begin
    cmd          = '0;
    cmd.restart  = pinEvt | wdtExpire;
    cmd.run      = ~isIdle;
    cmd.setTo    = wdtExpire & ~pinEvt;
    cmd.setPd    = wdtWake | (sleepMode & isIdle);
    cmd.clrFlags = flagClr & isIdle & ~cmd.restart;
  end

endmodule

// File: rtl/rst_source_path.sv
`timescale 1ns/1ps
module rst_source_path
  import rst_source_pkg::*;
#(
  parameter int LONG_CYCLES  = 1024,
  parameter int SHORT_CYCLES = 2
) (
  input  logic     clk,
  input  logic     powerOn,
  input  logic     fastStart,
  input  logic     xtalClk,
  input  flagCmd_t cmd,
  output logic     toFlag,
  output logic     pdFlag,
  output logic     cntDone
);

  localparam int CW = (LONG_CYCLES > 2) ? $clog2(LONG_CYCLES) : 1;
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lastCnt;
  logic          useShort;

  assign useShort = fastStart & ~xtalClk;
  assign lastCnt  = useShort ? SHORT_LAST : LONG_LAST;
  assign cntDone  = cmd.run & (cnt == lastCnt);

  always_ff @(posedge clk or posedge powerOn) begin
    if (powerOn) begin
      cnt <= '0;
    end else if (cmd.restart || cntDone) begin
      cnt <= '0;
    end else if (cmd.run) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge powerOn) begin
    if (powerOn) begin
      toFlag <= 1'b0;
      pdFlag <= 1'b0;
    end else begin
      toFlag <= (toFlag & ~cmd.clrFlags) | cmd.setTo;
      pdFlag <= (pdFlag & ~cmd.clrFlags) | cmd.setPd;
    end
  end

endmodule

// File: rtl/rst_source_ctrl.sv
`timescale 1ns/1ps
module rst_source_ctrl
  import rst_source_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int LONG_CYCLES  = 1024,
  parameter int SHORT_CYCLES = 2
) (
  input  logic clk,
  input  logic powerOn,
  input  logic extPin,
  input  logic lvrReq,
  input  logic wdtExpire,
  input  logic sleepMode,
  input  logic flagClr,
  input  logic fastStart,
  input  logic xtalClk,
  output logic toFlag,
  output logic pdFlag,
  output logic fullRst,
  output logic wakeRst
);

  flagCmd_t cmd;
  rstMode_e mode;
  logic     cntDone;
  logic     pinEvt;

  rst_source_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk(clk), .powerOn(powerOn), .extPin(extPin), .lvrReq(lvrReq),
    .wdtExpire(wdtExpire), .sleepMode(sleepMode), .flagClr(flagClr),
    .cntDone(cntDone), .cmd(cmd), .mode(mode), .pinEvt(pinEvt)
  );

  rst_source_path #(.LONG_CYCLES(LONG_CYCLES), .SHORT_CYCLES(SHORT_CYCLES)) u_path (
    .clk(clk), .powerOn(powerOn), .fastStart(fastStart), .xtalClk(xtalClk),
    .cmd(cmd), .toFlag(toFlag), .pdFlag(pdFlag), .cntDone(cntDone)
  );

  assign fullRst = (mode == MODE_FULL);
  assign wakeRst = (mode == MODE_WAKE);

endmodule

// File: rtl/rst_source_chk.sv
`timescale 1ns/1ps
module rst_source_chk (
  input logic clk,
  input logic powerOn,
  input logic wdtExpire,
  input logic sleepMode,
  input logic flagClr,
  input logic pinEvt,
  input logic toFlag,
  input logic pdFlag,
  input logic fullRst,
  input logic wakeRst
);

  always @(negedge clk) begin
    if (powerOn) begin
      a_r1_por_state: assert (!toFlag && !pdFlag && fullRst && !wakeRst)
        else $error("power-on state wrong");
    end
  end

  a_r2_pin_keeps_flags: assert property (@(posedge clk) disable iff (powerOn)
    pinEvt && !wdtExpire && !sleepMode |=> $stable(toFlag) && $stable(pdFlag) && fullRst);

  a_r3_wdt_sets_to: assert property (@(posedge clk) disable iff (powerOn)
    wdtExpire && !pinEvt |=> toFlag);

  a_r4_sleep_wdt_partial: assert property (@(posedge clk) disable iff (powerOn)
    wdtExpire && sleepMode && !pinEvt && !fullRst |=> wakeRst && !fullRst && pdFlag);

  a_r4_wake_excludes_full: assert property (@(posedge clk) disable iff (powerOn)
    wakeRst |-> !fullRst);

  a_r5_pin_wins: assert property (@(posedge clk) disable iff (powerOn)
    pinEvt && wdtExpire && !sleepMode |=> fullRst && $stable(toFlag));

  a_r7_request_asserts: assert property (@(posedge clk) disable iff (powerOn)
    pinEvt || wdtExpire |=> fullRst || wakeRst);

  a_r8_clear_ignored: assert property (@(posedge clk) disable iff (powerOn)
    flagClr && (fullRst || wakeRst) && !wdtExpire && !sleepMode && !pinEvt
    |=> $stable(toFlag) && $stable(pdFlag));

endmodule

bind rst_source_ctrl rst_source_chk u_chk (.*);

// File: tb/rst_source_ctrl_test.sv
`timescale 1ns/1ps
module rst_source_ctrl_test;

  logic clk = 1'b0;
  logic powerOn, extPin, lvrReq, wdtExpire, sleepMode, flagClr, fastStart, xtalClk;
  logic toFlag, pdFlag, fullRst, wakeRst;

  always #2.5 clk = ~clk;

  rst_source_ctrl uut (
    .clk(clk), .powerOn(powerOn), .extPin(extPin), .lvrReq(lvrReq),
    .wdtExpire(wdtExpire), .sleepMode(sleepMode), .flagClr(flagClr),
    .fastStart(fastStart), .xtalClk(xtalClk), .toFlag(toFlag),
    .pdFlag(pdFlag), .fullRst(fullRst), .wakeRst(wakeRst)
  );

  typedef struct {
    int        at;
    bit [3:0]  val;   // {to, pd, full, wake}
    string     tag;
  } expItem_t;

  expItem_t sbq[$];
  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectAt(input int at, input bit t, input bit p, input bit f,
                          input bit w, input string tag);
    expItem_t it;
    it.at = at; it.val = {t, p, f, w}; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        nChecks++;
        if ({toFlag, pdFlag, fullRst, wakeRst} !== sbq[i].val) begin
          nFail++;
          $display("FAIL %s at cycle %0d: got {to,pd,full,wake}=%b expected %b",
                   sbq[i].tag, cyc, {toFlag, pdFlag, fullRst, wakeRst}, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c;
    powerOn = 1'b1; extPin = 1'b0; lvrReq = 1'b0; wdtExpire = 1'b0;
    sleepMode = 1'b0; flagClr = 1'b0; fastStart = 1'b1; xtalClk = 1'b0;
    tick(3);
    expectAt(cyc + 1, 0, 0, 1, 0, "R1 power-on hold");
    tick(1);
    // R1 / R6: release after the short start-up length
    powerOn = 1'b0; c = cyc;
    expectAt(c + 1, 0, 0, 1, 0, "R6 short start-up first cycle");
    expectAt(c + 2, 0, 0, 0, 0, "R1 release after power-on");
    tick(3);

    // R3: watchdog while awake
    c = cyc; wdtExpire = 1'b1;
    expectAt(c + 1, 1, 0, 1, 0, "R3 watchdog full reset");
    expectAt(c + 2, 1, 0, 1, 0, "R6 short hold");
    expectAt(c + 3, 1, 0, 0, 0, "R6 short release");
    tick(1); wdtExpire = 1'b0; tick(3);

    // R8: software clear while idle
    c = cyc; flagClr = 1'b1;
    expectAt(c + 1, 0, 0, 0, 0, "R8 clear flags");
    tick(1); flagClr = 1'b0; tick(1);

    // R9: sleep sets PDF, and wins over a simultaneous clear
    c = cyc; sleepMode = 1'b1;
    expectAt(c + 1, 0, 1, 0, 0, "R9 sleep sets pd");
    tick(1);
    c = cyc; flagClr = 1'b1;
    expectAt(c + 1, 0, 1, 0, 0, "R9 sleep beats clear");
    tick(1); flagClr = 1'b0; tick(1);

    // R4: watchdog while asleep gives partial reset only
    c = cyc; wdtExpire = 1'b1;
    expectAt(c + 1, 1, 1, 0, 1, "R4 wake reset only");
    expectAt(c + 2, 1, 1, 0, 1, "R4 wake hold");
    expectAt(c + 3, 1, 1, 0, 0, "R4 wake release");
    tick(1); wdtExpire = 1'b0; tick(3);

    sleepMode = 1'b0; c = cyc; flagClr = 1'b1;
    expectAt(c + 1, 0, 0, 0, 0, "R8 clear after wake");
    tick(1); flagClr = 1'b0; tick(1);

    // R2: set TO first, then a pin reset leaves it untouched
    wdtExpire = 1'b1; tick(1); wdtExpire = 1'b0; tick(3);
    c = cyc; extPin = 1'b1;
    expectAt(c + 2, 1, 0, 0, 0, "R2 synchroniser delay");
    expectAt(c + 3, 1, 0, 1, 0, "R2 pin full reset flags kept");
    expectAt(c + 4, 1, 0, 1, 0, "R2 pin hold");
    expectAt(c + 5, 1, 0, 0, 0, "R2 pin release");
    tick(1); extPin = 1'b0; tick(5);

    // R5: low-voltage request and watchdog in the same cycle
    c = cyc; flagClr = 1'b1;
    expectAt(c + 1, 0, 0, 0, 0, "R8 clear before R5");
    tick(1); flagClr = 1'b0; tick(1);
    c = cyc; lvrReq = 1'b1;
    tick(1); lvrReq = 1'b0; tick(1);
    wdtExpire = 1'b1;
    expectAt(c + 3, 0, 0, 1, 0, "R5 pin wins, TO kept");
    expectAt(c + 5, 0, 0, 0, 0, "R5 release");
    tick(1); wdtExpire = 1'b0; tick(4);

    // R7: second request restarts the count
    c = cyc; wdtExpire = 1'b1;
    tick(1); wdtExpire = 1'b0; tick(1);
    wdtExpire = 1'b1;
    expectAt(c + 3, 1, 0, 1, 0, "R7 restart extends reset");
    expectAt(c + 4, 1, 0, 1, 0, "R7 restart hold");
    expectAt(c + 5, 1, 0, 0, 0, "R7 restart release");
    tick(1); wdtExpire = 1'b0; tick(4);

    // R6 long setting via fastStart=0, with R8 clear ignored during reset
    fastStart = 1'b0; c = cyc; wdtExpire = 1'b1;
    expectAt(c + 3, 1, 0, 1, 0, "R6 long still held");
    expectAt(c + 6, 1, 0, 1, 0, "R8 clear ignored during reset");
    expectAt(c + 1024, 1, 0, 1, 0, "R6 long last cycle");
    expectAt(c + 1025, 1, 0, 0, 0, "R6 long release");
    tick(1); wdtExpire = 1'b0; tick(4);
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
    while (cyc < c + 1027) tick(1);

    // R6 long setting forced by crystal clock
    fastStart = 1'b1; xtalClk = 1'b1; c = cyc; wdtExpire = 1'b1;
    expectAt(c + 3, 1, 0, 1, 0, "R6 crystal forces long");
    expectAt(c + 1025, 1, 0, 0, 0, "R6 crystal long release");
    tick(1); wdtExpire = 1'b0;
    while (cyc < c + 1027) tick(1);

    while (sbq.size() != 0) tick(1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run hung, got no finish expected finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule